// File: doc/BRIEF.md
# E1 Submultiframe Error Counter

This receive-side block keeps a single event counter that runs in one of two modes. In line mode it counts the code-violation pulses reported by the line decoder. In remote-report mode it counts the zero values carried in the Si bit of frames 13 and 15 of each received CRC-4 multiframe. The far end uses those Si bits to report the CRC errors it finds on the signal this end transmits. Through that mode the counter gives a view of the quality of the outgoing line.

The counter is 8 bits long by default. One control bit extends it to 10 bits, and in that setting its two upper bits are also shown on a separate status pair. The counter stops at its top value and does not wrap. A read strobe clears it. Apart from the counter, the block can route each detected CRC error to a level-active alarm interrupt, which stays set until a status read strobe arrives.

The framer drives the frame number (0 to 15 within the multiframe), a strobe that marks the Si bit of each frame, the multiframe lock flag and the event pulses.

Top module: `smf_err_counter`

## Requirements
- R1: After reset, `cnt_value` is 0, `cnt_ext` is 0 and `irq` is 0.
- R2: With `mode_si` = 0 (line mode), each cycle with `cv_pulse` = 1 adds one to `cnt_value` at the next clock edge. Si strobes have no effect in this mode.
- R3: With `mode_si` = 1, a cycle with `frame_stb` = 1, `si_bit` = 0 and `frame_idx` equal to 13 or 15 (4-bit binary) adds one. Every other frame number, `si_bit` = 1 and `cv_pulse` have no effect.
- R4: In remote-report mode, Si strobes are ignored while `mf_locked` = 0.
- R5: With `ext_len` = 0, the counter stops at 255. A value above 255 left over from 10-bit mode is brought down to 255 one cycle after `ext_len` falls.
- R6: With `ext_len` = 1, the counter stops at 1023, and `cnt_ext` shows `cnt_value[9:8]`. With `ext_len` = 0, `cnt_ext` is 0.
- R7: `rd_cnt` = 1 clears the counter at the next edge. A counted event in that same cycle is kept, so the counter then reads 1.
- R8: With `crc_irq_en` = 1, a `crc_err_pulse` sets `irq` at the next edge. With `crc_irq_en` = 0, the pulse leaves `irq` at 0.
- R9: `irq` stays at 1 until `rd_stat` = 1 clears it at the next edge. A new enabled CRC error in the same cycle as the read keeps `irq` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_idx | input | 4 | Frame number within the CRC multiframe, 0 to 15 |
| frame_stb | input | 1 | Marks the cycle in which `si_bit` of the current frame is valid |
| si_bit | input | 1 | Received Si bit |
| mf_locked | input | 1 | Receiver holds CRC multiframe alignment |
| cv_pulse | input | 1 | One-cycle code-violation event |
| crc_err_pulse | input | 1 | One-cycle CRC error event |
| mode_si | input | 1 | 1 selects remote-report counting, 0 selects line counting |
| ext_len | input | 1 | 1 selects the 10-bit counter length |
| crc_irq_en | input | 1 | Enables CRC errors as an interrupt source |
| rd_cnt | input | 1 | Counter read strobe; clears the counter |
| rd_stat | input | 1 | Status read strobe; clears the interrupt |
| cnt_value | output | 10 | Counter value |
| cnt_ext | output | 2 | Upper two counter bits in 10-bit mode |
| irq | output | 1 | Level-active alarm interrupt |

## Verification
The hardest state to reach from the ports is the 10-bit counter at its limit, followed by a drop to 8-bit length. The bench holds `cv_pulse` high for more than a thousand cycles in 10-bit mode. It checks a midway value and the ceiling, then lowers `ext_len` and looks for the clamp to 255. Clear strobes and interrupt reads are also placed in the same cycle as new events, to check which one takes priority.

// File: rtl/smf_cnt_pkg.sv
package smf_cnt_pkg;
   typedef enum logic {
      CNT_SRC_LINE = 1'b0,
      CNT_SRC_SI   = 1'b1
   } cnt_src_e;

   localparam int FRAMES_PER_MF = 16;
endpackage

// File: rtl/smf_evt_sel.sv
module smf_evt_sel
   import smf_cnt_pkg::*;
#(
   parameter int FRAME_W = 4,
   parameter int N_SI    = 2,
   parameter logic [N_SI*FRAME_W-1:0] SI_LIST = {4'd15, 4'd13}
) (
   input  logic               frame_stb,
   input  logic [FRAME_W-1:0] frame_idx,
   input  logic               si_bit,
   input  logic               mf_locked,
   input  logic               cv_pulse,
   input  cnt_src_e           src,
   output logic               evt
);
   logic [N_SI-1:0] hit;
   logic            si_evt;

   // one comparator per monitored frame number
   for (genvar i = 0; i < N_SI; i++) begin : g_hit
      assign hit[i] = (frame_idx == SI_LIST[i*FRAME_W +: FRAME_W]);
   end

   assign si_evt = frame_stb & mf_locked & ~si_bit & (|hit);

   always_comb begin
      unique case (src)
         CNT_SRC_SI:   evt = si_evt;
         default:      evt = cv_pulse;
      endcase
   end
endmodule

// File: rtl/smf_sat_cnt.sv
module smf_sat_cnt #(
   parameter int MAX_W    = 10,
   parameter int BASE_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             ext_len,
   output logic [MAX_W-1:0] cnt
);
   localparam logic [MAX_W-1:0] LIM_EXT  = {MAX_W{1'b1}};
   localparam logic [MAX_W-1:0] LIM_BASE = {{(MAX_W-BASE_W){1'b0}}, {BASE_W{1'b1}}};

   logic [MAX_W-1:0] limit;
   logic [MAX_W-1:0] bumped;
   logic [MAX_W-1:0] nxt;

   assign limit = ext_len ? LIM_EXT : LIM_BASE;

   // the variant picks what happens at the limit
   if (SATURATE) begin : g_sat
      assign bumped = (cnt >= limit) ? limit : cnt + 1'b1;
   end else begin : g_wrap
      assign bumped = (cnt >= limit) ? '0 : cnt + 1'b1;
   end

   always_comb begin
      if (clr)
         nxt = {{(MAX_W-1){1'b0}}, inc};
      else if (cnt > limit)
         nxt = limit;
      else if (inc)
         nxt = bumped;
      else
         nxt = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/smf_irq_latch.sv
module smf_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/smf_err_counter.sv
module smf_err_counter
   import smf_cnt_pkg::*;
#(
   parameter int FRAME_W  = 4,
   parameter int BASE_W   = 8,
   parameter int MAX_W    = 10,
   parameter int N_SI     = 2,
   parameter logic [N_SI*FRAME_W-1:0] SI_LIST = {4'd15, 4'd13},
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [FRAME_W-1:0]      frame_idx,
   input  logic                    frame_stb,
   input  logic                    si_bit,
   input  logic                    mf_locked,
   input  logic                    cv_pulse,
   input  logic                    crc_err_pulse,
   input  logic                    mode_si,
   input  logic                    ext_len,
   input  logic                    crc_irq_en,
   input  logic                    rd_cnt,
   input  logic                    rd_stat,
   output logic [MAX_W-1:0]        cnt_value,
   output logic [MAX_W-BASE_W-1:0] cnt_ext,
   output logic                    irq
);
   localparam int EXT_W = MAX_W - BASE_W;

   if (EXT_W < 1) begin : g_bad_len
      $error("MAX_W must exceed BASE_W");
   end
   if ((1 << FRAME_W) < FRAMES_PER_MF) begin : g_bad_frame
      $error("FRAME_W too narrow for the multiframe");
   end
   if (N_SI < 1) begin : g_bad_nsi
      $error("N_SI must be at least 1");
   end

   logic evt;

   smf_evt_sel #(
      .FRAME_W (FRAME_W),
      .N_SI    (N_SI),
      .SI_LIST (SI_LIST)
   ) u_sel (
      .frame_stb (frame_stb),
      .frame_idx (frame_idx),
      .si_bit    (si_bit),
      .mf_locked (mf_locked),
      .cv_pulse  (cv_pulse),
      .src       (cnt_src_e'(mode_si)),
      .evt       (evt)
   );

   smf_sat_cnt #(
      .MAX_W    (MAX_W),
      .BASE_W   (BASE_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (evt),
      .clr     (rd_cnt),
      .ext_len (ext_len),
      .cnt     (cnt_value)
   );

   assign cnt_ext = ext_len ? cnt_value[MAX_W-1:BASE_W] : '0;

   smf_irq_latch u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (crc_err_pulse & crc_irq_en),
      .clr   (rd_stat),
      .q     (irq)
   );
endmodule

// File: rtl/smf_err_counter_chk.sv
module smf_err_counter_chk #(
   parameter int MAX_W  = 10,
   parameter int BASE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mode_si,
   input logic                    mf_locked,
   input logic                    ext_len,
   input logic                    rd_cnt,
   input logic                    rd_stat,
   input logic                    crc_err_pulse,
   input logic                    crc_irq_en,
   input logic [MAX_W-1:0]        cnt_value,
   input logic [MAX_W-BASE_W-1:0] cnt_ext,
   input logic                    irq
);
   localparam logic [MAX_W-1:0] LIM_BASE = {{(MAX_W-BASE_W){1'b0}}, {BASE_W{1'b1}}};

   // R2
   step_of_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_cnt && ext_len) |=> (cnt_value >= $past(cnt_value)) && (cnt_value <= $past(cnt_value) + 1));

   // R4
   unlocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_si && !mf_locked && !rd_cnt && ext_len) |=> (cnt_value == $past(cnt_value)));

   // R5
   base_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_len |=> (cnt_value <= LIM_BASE));

   // R6
   ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_len && $past(!ext_len)) |-> (cnt_ext == '0));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt |=> (cnt_value <= 1));

   // R8
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err_pulse && crc_irq_en) |=> irq);

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_stat) |=> irq);

   // R9
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(crc_err_pulse && crc_irq_en));
endmodule

bind smf_err_counter smf_err_counter_chk #(
   .MAX_W  (MAX_W),
   .BASE_W (BASE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_si       (mode_si),
   .mf_locked     (mf_locked),
   .ext_len       (ext_len),
   .rd_cnt        (rd_cnt),
   .rd_stat       (rd_stat),
   .crc_err_pulse (crc_err_pulse),
   .crc_irq_en    (crc_irq_en),
   .cnt_value     (cnt_value),
   .cnt_ext       (cnt_ext),
   .irq           (irq)
);

// File: tb/sim_smf_err_counter.sv
`timescale 1ns/1ps
module sim_smf_err_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] frame_idx = '0;
   logic       frame_stb = 1'b0;
   logic       si_bit = 1'b1;
   logic       mf_locked = 1'b0;
   logic       cv_pulse = 1'b0;
   logic       crc_err_pulse = 1'b0;
   logic       mode_si = 1'b0;
   logic       ext_len = 1'b0;
   logic       crc_irq_en = 1'b0;
   logic       rd_cnt = 1'b0;
   logic       rd_stat = 1'b0;
   logic [9:0] cnt_value;
   logic [1:0] cnt_ext;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   smf_err_counter u0 (
      .clk (clk), .rst_n (rst_n), .frame_idx (frame_idx), .frame_stb (frame_stb),
      .si_bit (si_bit), .mf_locked (mf_locked), .cv_pulse (cv_pulse),
      .crc_err_pulse (crc_err_pulse), .mode_si (mode_si), .ext_len (ext_len),
      .crc_irq_en (crc_irq_en), .rd_cnt (rd_cnt), .rd_stat (rd_stat),
      .cnt_value (cnt_value), .cnt_ext (cnt_ext), .irq (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cv_burst(input int n);
      @(negedge clk) cv_pulse = 1'b1;
      repeat (n) @(negedge clk);
      cv_pulse = 1'b0;
   endtask

   task automatic clear_cnt();
      @(negedge clk) rd_cnt = 1'b1;
      @(negedge clk) rd_cnt = 1'b0;
   endtask

   // one multiframe; si value is used for every frame
   task automatic send_mf(input logic si);
      for (int f = 0; f < 16; f++) begin
         @(negedge clk);
         frame_idx = 4'(f);
         si_bit    = si;
         frame_stb = 1'b1;
         @(negedge clk) frame_stb = 1'b0;
      end
   endtask

   task automatic t_reset();
      check("R1 cnt_value", int'(cnt_value), 0);
      check("R1 cnt_ext", int'(cnt_ext), 0);
      check("R1 irq", int'(irq), 0);
   endtask

   task automatic t_line_mode();
      mode_si = 1'b0; mf_locked = 1'b1; ext_len = 1'b1;
      clear_cnt();
      cv_burst(5);
      check("R2 five violations", int'(cnt_value), 5);
      send_mf(1'b0);
      check("R2 Si ignored in line mode", int'(cnt_value), 5);
      clear_cnt();
      check("R7 clear", int'(cnt_value), 0);
   endtask

   task automatic t_si_mode();
      mode_si = 1'b1; mf_locked = 1'b1; ext_len = 1'b1;
      clear_cnt();
      send_mf(1'b0);
      check("R3 zeros in frames 13 and 15", int'(cnt_value), 2);
      send_mf(1'b1);
      check("R3 ones not counted", int'(cnt_value), 2);
      cv_burst(7);
      check("R3 violations ignored", int'(cnt_value), 2);
      send_mf(1'b0);
      check("R3 second multiframe", int'(cnt_value), 4);
   endtask

   task automatic t_unlocked();
      mode_si = 1'b1; mf_locked = 1'b0; ext_len = 1'b1;
      clear_cnt();
      send_mf(1'b0);
      check("R4 no count without lock", int'(cnt_value), 0);
      mf_locked = 1'b1;
   endtask

   task automatic t_lengths();
      mode_si = 1'b0; ext_len = 1'b0;
      clear_cnt();
      cv_burst(300);
      check("R5 stop at 255", int'(cnt_value), 255);
      check("R6 ext zero in 8-bit", int'(cnt_ext), 0);
      ext_len = 1'b1;
      clear_cnt();
      cv_burst(300);
      check("R6 value 300", int'(cnt_value), 300);
      check("R6 ext bits at 300", int'(cnt_ext), 1);
      cv_burst(800);
      check("R6 stop at 1023", int'(cnt_value), 1023);
      check("R6 ext bits at 1023", int'(cnt_ext), 3);
      @(negedge clk) ext_len = 1'b0;
      @(negedge clk);
      check("R5 clamp after length drop", int'(cnt_value), 255);
      check("R6 ext zero after drop", int'(cnt_ext), 0);
   endtask

   task automatic t_clear_race();
      mode_si = 1'b0; ext_len = 1'b1;
      clear_cnt();
      cv_burst(9);
      @(negedge clk) begin rd_cnt = 1'b1; cv_pulse = 1'b1; end
      @(negedge clk) begin rd_cnt = 1'b0; cv_pulse = 1'b0; end
      check("R7 event kept with clear", int'(cnt_value), 1);
   endtask

   task automatic t_irq();
      crc_irq_en = 1'b0;
      @(negedge clk) crc_err_pulse = 1'b1;
      @(negedge clk) crc_err_pulse = 1'b0;
      check("R8 masked source", int'(irq), 0);
      crc_irq_en = 1'b1;
      @(negedge clk) crc_err_pulse = 1'b1;
      @(negedge clk) crc_err_pulse = 1'b0;
      check("R8 enabled source", int'(irq), 1);
      repeat (10) @(negedge clk);
      check("R9 level held", int'(irq), 1);
      rd_stat = 1'b1;
      @(negedge clk) rd_stat = 1'b0;
      check("R9 cleared by read", int'(irq), 0);
      @(negedge clk) begin rd_stat = 1'b1; crc_err_pulse = 1'b1; end
      @(negedge clk) begin rd_stat = 1'b0; crc_err_pulse = 1'b0; end
      check("R9 new error wins over read", int'(irq), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_line_mode();
      t_si_mode();
      t_unlocked();
      t_lengths();
      t_clear_race();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule